// File: doc/BRIEF.md
# SDRAM Command Controller with Periodic Refresh

This block sits between a simple single-word request port and an external four-bank synchronous DRAM of 2048 rows by 256 columns of 32-bit words. After reset it brings the memory up. It waits out the power-up interval with NOP commands, closes every bank, issues two refreshes and programs the mode register. From then on it turns each accepted request into an ACTIVE command followed, after the row-to-column delay, by a READ or WRITE with auto precharge.

Read data is captured a programmable CAS latency (2 or 3 clocks) after the READ command and handed back with a one-cycle valid strobe. A free-running timer derived from the rule of 4096 refreshes per 64 ms raises a pending refresh. The pending refresh is served ahead of any new request as soon as the current access has finished. Each command is followed by NOPs for the timing delay that applies to it, and every such delay is a parameter counted in clock cycles.

The user sees a `ready` flag. A request is taken in the cycle where `req_valid` and `ready` are both high. `ready` then stays low until the whole command sequence, including the precharge recovery, has finished.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held and during the whole power-up wait, `ready` and `rd_valid` are low and the command pins {cs_n, ras_n, cas_n, we_n} carry NOP (0111).
- R2: Bring-up order: at least CLK_MHZ*INIT_US NOP cycles after reset, then PRECHARGE (0010) with A10 high, then two AUTO REFRESH (0001), then LOAD MODE (0000) with A[6:4] equal to CAS_LAT and all other A bits zero (burst length one, sequential), after which `ready` rises.
- R3: Command spacing: the next command after a PRECHARGE comes at least T_RP cycles later, the next command after an AUTO REFRESH at least T_RFC cycles later, and the next command after LOAD MODE at least 2 cycles later.
- R4: `req_addr` splits as bank = [20:19], row = [18:8], column = [7:0]. ACTIVE (0011) drives the bank on BA and the row on A. READ (0101) and WRITE (0100) drive the same bank and put the column on A[7:0] with A10 high (auto precharge) and A[9:8] zero.
- R5: READ or WRITE follows its ACTIVE by exactly T_RCD cycles, and ACTIVE comes in the cycle right after acceptance when no refresh is pending.
- R6: DQ is driven with the accepted `req_wdata` in the WRITE cycle only, with DQM 0000. At all other times the controller leaves DQ high-impedance.
- R7: Read data is sampled at the clock edge CAS_LAT edges after the one that registers READ. `rd_valid` is high for exactly one cycle, CAS_LAT+1 cycles after the READ cycle, with the stored word on `rd_data`.
- R8: A request is accepted only when `req_valid` and `ready` are high together. `ready` is low in the next cycle and stays low until the sequence is done; for a read that is after `rd_valid`. A request held high while `ready` is low starts no ACTIVE. While `ready` is high the command pins carry NOP.
- R9: After bring-up an AUTO REFRESH is issued every CLK_MHZ*REF_WINDOW_US/REF_COUNT cycles when idle. No gap between refreshes exceeds that interval plus the longest access sequence.
- R10: When a refresh is pending, `ready` is low, and the refresh is issued before the ACTIVE of any request waiting at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands and data on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Captured read data |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| ready | output | 1 | Controller can accept a request this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 11 | Row / column / mode address bus |
| sd_dqm | output | 4 | Byte masks, high during bring-up |
| sd_dq | inout | 32 | Bidirectional data bus |

## Verification
A wrong wait count or return state shows at the command pins within one delay window. Two commands then come too close together, or the ACTIVE-to-column gap differs from T_RCD. A faulty read pipeline shows on the first read: `rd_valid` lands on the wrong cycle, or the sampled word differs from the one the memory model put on DQ. A broken refresh timer or pending flag shows within one refresh interval, as a missing or late AUTO REFRESH or as an ACTIVE issued ahead of a pending refresh.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int CLK_MHZ       = 200,
  parameter int INIT_US       = 100,
  parameter int REF_WINDOW_US = 64000,
  parameter int REF_COUNT     = 4096,
  parameter int CAS_LAT       = 3,
  parameter int T_RCD         = 3,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 10,
  parameter int T_WR          = 2,
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 11,
  parameter int COL_W         = 8,
  parameter int DATA_W        = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            rd_valid,
  output logic                            ready,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_a,
  output logic [DATA_W/8-1:0]             sd_dqm,
  inout  wire  [DATA_W-1:0]               sd_dq
);

  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int REFI_CYC = (CLK_MHZ * REF_WINDOW_US) / REF_COUNT;
  localparam int CNT_W    = $clog2(INIT_CYC + T_RFC + T_RCD + T_WR + T_RP + CAS_LAT + 4);
  localparam int REF_W    = $clog2(REFI_CYC + 1);
  localparam int AP_BIT   = 10;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;

  typedef enum logic [3:0] {
    S_POWERUP, S_PALL, S_REF, S_LMR, S_IDLE, S_ACT, S_RD, S_WR, S_WAIT
  } state_t;

  state_t             st, ret;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         init_refs;
  logic               booted;
  logic [REF_W-1:0]   ref_tmr;
  logic               ref_pend;
  logic [BANK_W-1:0]  bank_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               wr_q;
  logic [CAS_LAT-1:0] rd_pipe;
  logic [3:0]         cmd;

  assign ready  = (st == S_IDLE) && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dqm = booted ? '0 : '1;
  assign sd_dq  = (st == S_WR) ? wdata_q : {DATA_W{1'bz}};

  always_comb begin
    cmd   = C_NOP;
    sd_a  = '0;
    sd_ba = '0;
    unique case (st)
      S_PALL: begin cmd = C_PRE; sd_a = AP_MASK; end
      S_REF:  cmd = C_REF;
      S_LMR:  begin cmd = C_LMR; sd_a = MODE_WORD; end
      S_ACT:  begin cmd = C_ACT; sd_a = row_q; sd_ba = bank_q; end
      S_RD:   begin cmd = C_RD;  sd_a = AP_MASK | ROW_W'(col_q); sd_ba = bank_q; end
      S_WR:   begin cmd = C_WR;  sd_a = AP_MASK | ROW_W'(col_q); sd_ba = bank_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_POWERUP;
      ret       <= S_IDLE;
      cnt       <= CNT_W'(INIT_CYC - 1);
      init_refs <= '0;
      booted    <= 1'b0;
      bank_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
    end else begin
      unique case (st)
        S_POWERUP: begin
          if (cnt == '0) st <= S_PALL;
          else cnt <= cnt - 1'b1;
        end
        S_PALL: begin
          st        <= S_WAIT;
          cnt       <= CNT_W'(T_RP - 2);
          ret       <= S_REF;
          init_refs <= 2'd2;
        end
        S_REF: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RFC - 2);
          if (!booted) begin
            init_refs <= init_refs - 1'b1;
            ret       <= (init_refs == 2'd1) ? S_LMR : S_REF;
          end else begin
            ret <= S_IDLE;
          end
        end
        S_LMR: begin
          st     <= S_WAIT;
          cnt    <= '0;
          ret    <= S_IDLE;
          booted <= 1'b1;
        end
        S_IDLE: begin
          if (ref_pend) begin
            st <= S_REF;
          end else if (req_valid) begin
            st      <= S_ACT;
            bank_q  <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
            row_q   <= req_addr[ROW_W+COL_W-1 -: ROW_W];
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            wr_q    <= req_write;
          end
        end
        S_ACT: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RCD - 2);
          ret <= wr_q ? S_WR : S_RD;
        end
        S_RD: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(CAS_LAT + T_RP - 2);
          ret <= S_IDLE;
        end
        S_WR: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_WR + T_RP - 2);
          ret <= S_IDLE;
        end
        S_WAIT: begin
          if (cnt == '0) st <= ret;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_tmr  <= REF_W'(REFI_CYC - 1);
      ref_pend <= 1'b0;
    end else begin
      if (st == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (booted) begin
        if (ref_tmr == '0) begin
          ref_tmr  <= REF_W'(REFI_CYC - 1);
          ref_pend <= 1'b1;
        end else begin
          ref_tmr <= ref_tmr - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[CAS_LAT-2:0], (st == S_RD)};
      rd_valid <= rd_pipe[CAS_LAT-1];
      if (rd_pipe[CAS_LAT-1]) rd_data <= sd_dq;
    end
  end

endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int CAS_LAT  = 3,
  parameter int T_RCD    = 3,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int T_WR     = 2,
  parameter int REFI_CYC = 3125
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       sd_a10,
  input logic       req_valid,
  input logic       ready,
  input logic       rd_valid
);

  localparam int SLACK = T_RCD + T_WR + T_RP + CAS_LAT + 4;

  logic [3:0] last_cmd;
  int         gap;
  int         since_ref;
  logic       up;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready); // R8

  AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == 4'b0111)); // R8

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd == 4'b0101, CAS_LAT + 1)); // R7

  AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> sd_a10); // R4

  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !up |-> !ready); // R1

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd  <= 4'b0111;
      gap       <= 0;
      since_ref <= 0;
      up        <= 1'b0;
    end else begin
      gap       <= gap + 1;
      since_ref <= since_ref + 1;
      if (cmd != 4'b0111) begin
        AST_RFC_SPACING: assert (last_cmd != 4'b0001 || gap >= T_RFC); // R3
        AST_RP_SPACING: assert (last_cmd != 4'b0010 || gap >= T_RP); // R3
        AST_MRD_SPACING: assert (last_cmd != 4'b0000 || gap >= 2); // R3
        AST_RCD_EXACT: assert (last_cmd != 4'b0011 || gap == T_RCD); // R5
        last_cmd <= cmd;
        gap      <= 1;
      end
      if (cmd == 4'b0000) up <= 1'b1;
      if (cmd == 4'b0001 || cmd == 4'b0000) since_ref <= 1;
      AST_REFRESH_DUE: assert (!up || since_ref <= REFI_CYC + SLACK); // R9
    end
  end

endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(
  .CAS_LAT (CAS_LAT),
  .T_RCD   (T_RCD),
  .T_RP    (T_RP),
  .T_RFC   (T_RFC),
  .T_WR    (T_WR),
  .REFI_CYC((CLK_MHZ * REF_WINDOW_US) / REF_COUNT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .sd_a10   (sd_a[10]),
  .req_valid(req_valid),
  .ready    (ready),
  .rd_valid (rd_valid)
);

// File: tb/test_sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module test_sdram_cmd_ctrl;

  localparam int CLK_MHZ = 200, INIT_US = 1, WIN_US = 4096, NREF = 4096;
  localparam int CL = 3, T_RCD = 3, T_RP = 3, T_RFC = 8, T_WR = 2;
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int REFI = (CLK_MHZ * WIN_US) / NREF;
  localparam int SLACK = T_RCD + T_WR + T_RP + CL + 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid, ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [10:0] a;
  logic [3:0] dqm;
  wire  [31:0] dq;
  logic [31:0] mdl_dq = '0;
  logic mdl_oe = 1'b0;

  assign dq = mdl_oe ? mdl_dq : 32'bz;
  always #2.5 clk = ~clk;

  sdram_cmd_ctrl #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .REF_WINDOW_US(WIN_US),
    .REF_COUNT(NREF), .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_WR(T_WR)) i_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .ready(ready), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_a(a), .sd_dqm(dqm), .sd_dq(dq));

  int checks = 0, errors = 0, cyc = 0;
  wire [3:0] bcmd = {cs_n, ras_n, cas_n, we_n};

  logic [31:0] mem [int unsigned];
  logic [10:0] open_row [4];
  logic        pv [CL+1];
  logic [31:0] pd [CL+1];
  logic [3:0]  init_c [4];
  logic [10:0] init_a [4];
  int          init_t [4];
  int n_init = 0, last_cmd_cyc = 0, ref_cyc = 0, max_ref_gap = 0, last_ref_gap = 0;
  int space_err = 0, rcd_err = 0, hiz_err = 0, ref_n = 0, act_n = 0;
  int act_cyc = 0, rd_cyc = 0, wr_cyc = 0, rv_cyc = 0, lmr_cyc = 0;
  logic [3:0]  last_cmd = 4'b0111;
  logic [1:0]  act_ba, rw_ba;
  logic [10:0] act_row, rw_a;
  logic [31:0] wr_dq, rv_data;
  logic [3:0]  wr_dqm;
  logic        up = 1'b0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int j = CL; j > 0; j--) begin pv[j] = pv[j-1]; pd[j] = pd[j-1]; end
    pv[0] = 1'b0; pd[0] = '0;
    if (rst_n) begin
      if (bcmd != C_WR && !mdl_oe && dq !== 32'bz) hiz_err++;
      if (rd_valid) begin rv_cyc = cyc; rv_data = rd_data; end
      if (bcmd != C_NOP) begin
        if (last_cmd == C_REF && cyc - last_cmd_cyc < T_RFC) space_err++;
        if (last_cmd == C_PRE && cyc - last_cmd_cyc < T_RP) space_err++;
        if (last_cmd == C_LMR && cyc - last_cmd_cyc < 2) space_err++;
        if (last_cmd == C_ACT && (bcmd == C_RD || bcmd == C_WR) && cyc - last_cmd_cyc != T_RCD)
          rcd_err++;
        if (n_init < 4) begin
          init_c[n_init] = bcmd; init_a[n_init] = a; init_t[n_init] = cyc; n_init++;
        end
        case (bcmd)
          C_ACT: begin open_row[ba] = a; act_cyc = cyc; act_ba = ba; act_row = a; act_n++; end
          C_WR: begin
            wr_cyc = cyc; rw_ba = ba; rw_a = a; wr_dq = dq; wr_dqm = dqm;
            mem[{ba, open_row[ba], a[7:0]}] = dq;
          end
          C_RD: begin
            rd_cyc = cyc; rw_ba = ba; rw_a = a;
            pv[0] = 1'b1;
            pd[0] = mem.exists({ba, open_row[ba], a[7:0]}) ? mem[{ba, open_row[ba], a[7:0]}] : 32'hDEAD_0000;
          end
          C_REF: if (up) begin
            last_ref_gap = cyc - ref_cyc;
            if (last_ref_gap > max_ref_gap) max_ref_gap = last_ref_gap;
            ref_cyc = cyc; ref_n++;
          end
          C_LMR: begin up = 1'b1; ref_cyc = cyc; lmr_cyc = cyc; end
          default: ;
        endcase
        last_cmd = bcmd; last_cmd_cyc = cyc;
      end
    end
    mdl_oe = pv[CL]; mdl_dq = pd[CL];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wait_ready(output int done);
    int n = 0;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
    done = cyc;
  endtask

  task automatic issue(input bit wr, input logic [20:0] addr, input logic [31:0] d,
                       output int acc, output int done);
    @(negedge clk);
    req_write = wr; req_addr = addr; req_wdata = d; req_valid = 1'b1;
    wait_ready(acc);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~addr; req_wdata = ~d;
    chk(!ready, "R8 ready low after accept", 32'(ready), 0);
    wait_ready(done);
  endtask

  task automatic do_write(input logic [20:0] addr, input logic [31:0] d);
    int acc, done;
    issue(1'b1, addr, d, acc, done);
    chk(act_cyc == acc + 1, "R5 ACTIVE right after accept", act_cyc, acc + 1);
    chk(act_ba == addr[20:19] && act_row == addr[18:8], "R4 ACTIVE bank/row",
        {act_ba, act_row}, {addr[20:19], addr[18:8]});
    chk(wr_cyc == act_cyc + T_RCD, "R5 WRITE after T_RCD", wr_cyc - act_cyc, T_RCD);
    chk(rw_ba == addr[20:19] && rw_a == {3'b100, addr[7:0]}, "R4 WRITE bank/column/A10",
        {rw_ba, rw_a}, {addr[20:19], 3'b100, addr[7:0]});
    chk(wr_dq == d && wr_dqm == 4'h0, "R6 write data and mask", wr_dq, d);
  endtask

  task automatic do_read(input logic [20:0] addr, input logic [31:0] d);
    int acc, done;
    issue(1'b0, addr, 32'h0, acc, done);
    chk(rd_cyc == act_cyc + T_RCD, "R5 READ after T_RCD", rd_cyc - act_cyc, T_RCD);
    chk(rw_ba == addr[20:19] && rw_a == {3'b100, addr[7:0]}, "R4 READ bank/column/A10",
        {rw_ba, rw_a}, {addr[20:19], 3'b100, addr[7:0]});
    chk(rv_cyc == rd_cyc + CL + 1, "R7 rd_valid latency", rv_cyc - rd_cyc, CL + 1);
    chk(rv_data == d, "R7 read data", rv_data, d);
    chk(done > rv_cyc, "R8 ready after rd_valid", done, rv_cyc + 1);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(!ready && !rd_valid && bcmd == C_NOP, "R1 in reset", {ready, rd_valid, bcmd}, {2'b00, C_NOP});
    rst_n = 1'b1;
    repeat (INIT_CYC / 2) @(negedge clk);
    chk(!ready && !rd_valid && bcmd == C_NOP && n_init == 0, "R1 during power-up wait",
        {ready, rd_valid, bcmd}, {2'b00, C_NOP});
  endtask

  task automatic t_init();
    int done;
    wait_ready(done);
    chk(n_init == 4, "R2 bring-up command count", n_init, 4);
    chk(init_c[0] == C_PRE && init_a[0][10], "R2 precharge all", {init_c[0], init_a[0]}, {C_PRE, 11'h400});
    chk(init_t[0] >= INIT_CYC, "R2 power-up wait length", init_t[0], INIT_CYC);
    chk(init_c[1] == C_REF && init_c[2] == C_REF, "R2 two refreshes", {init_c[1], init_c[2]}, {C_REF, C_REF});
    chk(init_c[3] == C_LMR && init_a[3] == 11'(CL << 4), "R2 mode word", {init_c[3], init_a[3]},
        {C_LMR, 11'(CL << 4)});
    chk(init_t[1] - init_t[0] >= T_RP && init_t[2] - init_t[1] >= T_RFC, "R3 bring-up spacing",
        init_t[2] - init_t[1], T_RFC);
    chk(done >= lmr_cyc + 2, "R3 ready after mode load", done - lmr_cyc, 2);
  endtask

  task automatic t_basic();
    do_write({2'd1, 11'd5, 8'd9}, 32'hCAFE_F00D);
    do_read({2'd1, 11'd5, 8'd9}, 32'hCAFE_F00D);
  endtask

  task automatic t_banks();
    do_write({2'd0, 11'd0, 8'd0}, 32'h1111_0000);
    do_write({2'd1, 11'd2047, 8'd255}, 32'h2222_FFFF);
    do_write({2'd2, 11'd1024, 8'd128}, 32'h3333_8080);
    do_write({2'd3, 11'd1, 8'd254}, 32'h4444_0101);
    do_read({2'd3, 11'd1, 8'd254}, 32'h4444_0101);
    do_read({2'd0, 11'd0, 8'd0}, 32'h1111_0000);
    do_read({2'd2, 11'd1024, 8'd128}, 32'h3333_8080);
    do_read({2'd1, 11'd2047, 8'd255}, 32'h2222_FFFF);
  endtask

  task automatic t_overwrite();
    do_write({2'd2, 11'd77, 8'd3}, 32'hAAAA_5555);
    do_write({2'd2, 11'd77, 8'd3}, 32'h5555_AAAA);
    do_read({2'd2, 11'd77, 8'd3}, 32'h5555_AAAA);
  endtask

  task automatic t_refresh();
    int n0 = ref_n;
    repeat (3 * REFI + 2) @(negedge clk);
    chk(ref_n - n0 >= 3, "R9 refresh count while idle", ref_n - n0, 3);
    chk(last_ref_gap == REFI, "R9 idle refresh period", last_ref_gap, REFI);
  endtask

  task automatic t_priority();
    int n = 0, t0, a0, acc, done;
    @(negedge clk);
    while (ready && n < 2 * REFI) begin @(negedge clk); n++; end
    t0 = cyc; a0 = act_n;
    chk(!ready && bcmd == C_NOP, "R10 ready low on pending refresh", 32'(ready), 0);
    req_write = 1'b1; req_addr = {2'd0, 11'd9, 8'd9}; req_wdata = 32'h0BAD_BEEF; req_valid = 1'b1;
    wait_ready(acc);
    chk(act_n == a0, "R8 no ACTIVE while ready low", act_n - a0, 0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_ready(done);
    chk(ref_cyc > t0 && act_cyc > ref_cyc, "R10 refresh before waiting request", ref_cyc, act_cyc);
    chk(act_n == a0 + 1, "R8 one ACTIVE per request", act_n - a0, 1);
    do_read({2'd0, 11'd9, 8'd9}, 32'h0BAD_BEEF);
  endtask

  task automatic t_final();
    chk(space_err == 0, "R3 command spacing", space_err, 0);
    chk(rcd_err == 0, "R5 ACTIVE to column gap", rcd_err, 0);
    chk(hiz_err == 0, "R6 DQ released outside WRITE", hiz_err, 0);
    chk(max_ref_gap <= REFI + SLACK, "R9 worst refresh gap", max_ref_gap, REFI + SLACK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    summary();
    $finish;
  end

  initial begin
    for (int j = 0; j <= CL; j++) begin pv[j] = 1'b0; pd[j] = '0; end
    t_reset();
    t_init();
    t_basic();
    t_banks();
    t_overwrite();
    t_refresh();
    t_priority();
    repeat (REFI) @(negedge clk);
    t_final();
    summary();
    $finish;
  end

endmodule